// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block drives the system reset line of a microcontroller supervisor. Three causes request reset: the power-up of the block itself (modelled by the synchronous `rst` input), a low supply-good flag from an external comparator, and expiry of a watchdog that the host must restart by pulling the chip-select/watchdog line from high to low. All three causes share one hold timer. Reset stays asserted until the supply has been good for a fixed number of millisecond ticks with no new cause arriving.

A free-running prescaler outside the block supplies the millisecond tick. Every period is a parameter counted in ticks, so the nominal 200 ms hold time and the 1.4 s, 600 ms and 200 ms watchdog periods can be scaled down. A 2-bit period code from the status register selects the watchdog period, and one code value turns the watchdog off. A parameter sets whether the reset pin is active-low or active-high. A separate active-high flag reports that reset is in force, so that command decode can refuse reads and writes while it is set.

Top module: `sup_reset_ctrl`

## Requirements
- R1: After `rst`, reset is active. It is released on the clock edge that samples the HOLD_TICKS-th `ms_tick` counted while `supply_ok` has stayed high without a break, and not earlier.
- R2: A low `supply_ok` asserts reset on the next clock edge, even during a hold. It also restarts the hold count from zero, so the hold needs HOLD_TICKS ticks again after the supply returns.
- R3: Period code mapping is 2'b00 = WD_TICKS_LONG ticks, 2'b01 = WD_TICKS_MID ticks, 2'b10 = WD_TICKS_SHORT ticks, and 2'b11 = watchdog off. With the code at 2'b11, reset never comes from the watchdog.
- R4: Only a high-to-low transition of `cs_wdi`, seen through a two-flop synchronizer, restarts the watchdog count. A steady high level, a steady low level or a rising edge leaves the count running.
- R5: When the watchdog count reaches the selected period, reset asserts within two clock edges. The hold rule of R1 then applies before release.
- R6: With ACTIVE_LOW = 1, `rst_out` is 0 while reset is active and 1 otherwise. With ACTIVE_LOW = 0 the levels are the other way round.
- R7: `rst_active` is 1 exactly while reset is active, whatever the pin polarity.
- R8: The watchdog count is held at zero while reset is active and starts from zero when reset is released. Ticks that arrive during the hold never count toward expiry.
- R9: Any change of `wd_code` restarts the watchdog count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond from the prescaler |
| supply_ok | input | 1 | Supply-good comparator flag, synchronous to clk |
| cs_wdi | input | 1 | Chip-select / watchdog kick line, asynchronous |
| wd_code | input | 2 | Watchdog period code from the status register |
| rst_out | output | 1 | Reset pin level, polarity set by ACTIVE_LOW |
| rst_active | output | 1 | High while reset is in force, used to gate commands |

## Verification
The assertions take `ms_tick` to be a single-cycle pulse and `supply_ok` to be already synchronous to `clk`. They also take any watchdog expiry to be the result of a counted tick. The stimulus holds every tick high for exactly one cycle and leaves at least three idle cycles after each one. It also separates each `cs_wdi` edge from the next tick by several cycles, so the two synchronizer stages settle before the watchdog counter sees the kick. The random phase mixes kicks and ticks in the mid-period mode. It keeps its own count of ticks since the last kick and expects reset exactly when that count reaches the period.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_code_e;
endpackage

// File: rtl/sup_edge_sync.sv
module sup_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= chain[STAGES-1];
  end

  assign fall = last_q & ~chain[STAGES-1];

  // R4
  fall_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog
  import sup_pkg::*;
#(
  parameter int TICKS_LONG  = 1400,
  parameter int TICKS_MID   = 600,
  parameter int TICKS_SHORT = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       kick,
  input  logic       hold,
  input  logic [1:0] code,
  output logic       fire
);
  localparam int MAX_A = (TICKS_LONG > TICKS_MID) ? TICKS_LONG : TICKS_MID;
  localparam int MAX_T = (MAX_A > TICKS_SHORT) ? MAX_A : TICKS_SHORT;
  localparam int CW    = $clog2(MAX_T + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last_idx;
  logic [1:0]    code_q;
  logic          enabled;
  logic          restart;

  always_comb begin
    case (wd_code_e'(code))
      WD_LONG:  last_idx = CW'(TICKS_LONG - 1);
      WD_MID:   last_idx = CW'(TICKS_MID - 1);
      WD_SHORT: last_idx = CW'(TICKS_SHORT - 1);
      default:  last_idx = '0;
    endcase
  end

  assign enabled = (wd_code_e'(code) != WD_OFF);
  assign restart = hold | ~enabled | kick | (code != code_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      fire   <= 1'b0;
      code_q <= code;
    end else begin
      fire   <= 1'b0;
      code_q <= code;
      if (restart) begin
        cnt <= '0;
      end else if (ms_tick) begin
        if (cnt == last_idx) begin
          fire <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3
  wd_off_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> ($past(code) != 2'b11));

  // R5
  fire_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(ms_tick));

  // R8
  no_fire_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> !$past(hold));
endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
  parameter int HOLD_TICKS = 200,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic supply_ok,
  input  logic wd_fire,
  output logic active,
  output logic pin
);
  localparam int CW = $clog2(HOLD_TICKS + 1);

  logic [CW-1:0] cnt, cnt_d;
  logic          act_d;

  always_comb begin
    act_d = active;
    cnt_d = cnt;
    if (!supply_ok || wd_fire) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (active && ms_tick) begin
      if (cnt == CW'(HOLD_TICKS - 1)) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b1;
      cnt    <= '0;
      pin    <= ~ACTIVE_LOW;
    end else begin
      active <= act_d;
      cnt    <= cnt_d;
      pin    <= ACTIVE_LOW ? ~act_d : act_d;
    end
  end

  // R2
  supply_low_chk: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> active);

  // R1
  release_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> ($past(ms_tick) && $past(supply_ok)));
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int HOLD_TICKS     = 200,
  parameter int WD_TICKS_LONG  = 1400,
  parameter int WD_TICKS_MID   = 600,
  parameter int WD_TICKS_SHORT = 200,
  parameter int SYNC_STAGES    = 2,
  parameter bit ACTIVE_LOW     = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       supply_ok,
  input  logic       cs_wdi,
  input  logic [1:0] wd_code,
  output logic       rst_out,
  output logic       rst_active
);
  logic kick;
  logic wd_fire;

  sup_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (cs_wdi),
    .fall (kick)
  );

  sup_watchdog #(
    .TICKS_LONG  (WD_TICKS_LONG),
    .TICKS_MID   (WD_TICKS_MID),
    .TICKS_SHORT (WD_TICKS_SHORT)
  ) u_wd (
    .clk     (clk),
    .rst     (rst),
    .ms_tick (ms_tick),
    .kick    (kick),
    .hold    (rst_active),
    .code    (wd_code),
    .fire    (wd_fire)
  );

  sup_hold_timer #(
    .HOLD_TICKS (HOLD_TICKS),
    .ACTIVE_LOW (ACTIVE_LOW)
  ) u_hold (
    .clk       (clk),
    .rst       (rst),
    .ms_tick   (ms_tick),
    .supply_ok (supply_ok),
    .wd_fire   (wd_fire),
    .active    (rst_active),
    .pin       (rst_out)
  );

  // R5
  fire_asserts_chk: assert property (@(posedge clk) disable iff (rst)
    wd_fire |=> rst_active);

  // R6
  polarity_chk: assert property (@(posedge clk) disable iff (rst)
    rst_out == (ACTIVE_LOW ? !rst_active : rst_active));
endmodule

// File: tb/sup_reset_ctrl_test.sv
module sup_reset_ctrl_test;
  localparam int HOLD = 5;
  localparam int TL   = 12;
  localparam int TM   = 8;
  localparam int TS   = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic       ms_tick;
  logic       supply_ok;
  logic       cs_wdi;
  logic [1:0] wd_code;
  logic       rst_out, rst_active;
  logic       rst_out_hi, act_hi;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  sup_reset_ctrl #(.HOLD_TICKS(HOLD), .WD_TICKS_LONG(TL), .WD_TICKS_MID(TM),
                   .WD_TICKS_SHORT(TS), .ACTIVE_LOW(1'b1)) uut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .supply_ok(supply_ok),
    .cs_wdi(cs_wdi), .wd_code(wd_code), .rst_out(rst_out), .rst_active(rst_active));

  sup_reset_ctrl #(.HOLD_TICKS(HOLD), .WD_TICKS_LONG(TL), .WD_TICKS_MID(TM),
                   .WD_TICKS_SHORT(TS), .ACTIVE_LOW(1'b0)) uut_hi (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .supply_ok(supply_ok),
    .cs_wdi(cs_wdi), .wd_code(wd_code), .rst_out(rst_out_hi), .rst_active(act_hi));

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // expected pin level from requirement R6
  function automatic logic pin_level(input logic active, input bit low);
    return low ? ~active : active;
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic kick();
    @(negedge clk) cs_wdi = 1'b0;
    repeat (4) @(negedge clk);
    cs_wdi = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic recover(input string req);
    tick(HOLD - 1);
    chk(req, rst_active, 1'b1);
    tick(1);
    chk(req, rst_active, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int since;
    rst = 1'b1; ms_tick = 1'b0; supply_ok = 1'b0; cs_wdi = 1'b1; wd_code = 2'b11;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state", rst_active, 1'b1);
    chk("R6 low pin", rst_out, pin_level(1'b1, 1'b1));
    chk("R6 high pin", rst_out_hi, pin_level(1'b1, 1'b0));
    tick(3);
    chk("R2 supply low holds", rst_active, 1'b1);
    supply_ok = 1'b1;
    recover("R1 power-up hold");
    chk("R7 inactive", rst_active, 1'b0);
    chk("R6 low pin idle", rst_out, pin_level(1'b0, 1'b1));
    chk("R6 high pin idle", rst_out_hi, pin_level(1'b0, 1'b0));

    tick(30);
    chk("R3 disabled code", rst_active, 1'b0);

    // brown-out with broken hold
    @(negedge clk) supply_ok = 1'b0;
    @(negedge clk);
    chk("R2 brown-out asserts", rst_active, 1'b1);
    supply_ok = 1'b1;
    tick(3);
    @(negedge clk) supply_ok = 1'b0;
    @(negedge clk) supply_ok = 1'b1;
    recover("R2 hold restarted");

    // short period
    wd_code = 2'b10;
    tick(TS - 1);
    chk("R3 short not yet", rst_active, 1'b0);
    tick(1);
    chk("R5 short expiry", rst_active, 1'b1);
    chk("R7 active on expiry", act_hi, 1'b1);
    recover("R5 hold after expiry");
    tick(TS - 1);
    chk("R8 count from zero", rst_active, 1'b0);
    tick(1);
    chk("R8 expiry after release", rst_active, 1'b1);
    recover("R5 recover");

    // kick restarts
    tick(TS - 1);
    kick();
    tick(TS - 1);
    chk("R4 kick restarts", rst_active, 1'b0);
    tick(1);
    chk("R4 expiry after kick", rst_active, 1'b1);
    recover("R4 recover");

    // steady low does not restart
    @(negedge clk) cs_wdi = 1'b0;
    repeat (4) @(negedge clk);
    tick(TS - 1);
    chk("R4 low level", rst_active, 1'b0);
    tick(1);
    chk("R4 steady low expires", rst_active, 1'b1);
    recover("R4 recover low");
    tick(2);
    @(negedge clk) cs_wdi = 1'b1;
    repeat (4) @(negedge clk);
    tick(TS - 2);
    chk("R4 rising edge ignored", rst_active, 1'b1);
    recover("R4 recover rise");

    // code change restarts
    tick(TS - 1);
    @(negedge clk) wd_code = 2'b01;
    repeat (2) @(negedge clk);
    tick(TM - 1);
    chk("R9 code change restart", rst_active, 1'b0);
    tick(1);
    chk("R9 mid expiry", rst_active, 1'b1);
    recover("R9 recover");

    // long period
    @(negedge clk) wd_code = 2'b00;
    repeat (2) @(negedge clk);
    tick(TL - 1);
    chk("R3 long not yet", rst_active, 1'b0);
    tick(1);
    chk("R3 long expiry", rst_active, 1'b1);
    recover("R3 recover");

    // random kicks and ticks in mid mode
    @(negedge clk) wd_code = 2'b01;
    repeat (2) @(negedge clk);
    void'($urandom(32'd1234));
    since = 0;
    for (int it = 0; it < 120; it++) begin
      if ($urandom % 4 == 0) begin
        kick();
        since = 0;
      end else begin
        tick(1);
        since++;
      end
      chk("R4 random", rst_active, (since >= TM) ? 1'b1 : 1'b0);
      if (since >= TM) begin
        recover("R5 random recover");
        since = 0;
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule